// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block counts system clock cycles and expects software to clear it with a strobe before a chosen period runs out. It offers three power-of-two periods, 2^16, 2^18 and 2^20 cycles by default. An expired period is taken as a software processing error. The first error raises a one-cycle non-maskable interrupt request. The block then keeps counting from zero.

If a second period expires with no clear in between, the block raises a system reset request instead, and stretches it over a fixed number of clocks. A clear strobe, or a change of the period select while counting, starts a fresh period. Dropping the enable parks the whole block at zero.

Top module: `two_strike_wdt`

## Requirements
- R1: After a synchronous reset, `nmi_req_o` and `rst_req_o` are low, and the strike flag and the counter are zero.
- R2: Period select encoding: 0 gives 2^P0_EXP cycles, 1 gives 2^P1_EXP cycles, 2 gives 2^P2_EXP cycles, and 3 behaves like 2. When the clear strobe is sampled at clock edge t, the timeout request appears at the output after edge t + 2^E.
- R3: The first timeout pulses `nmi_req_o` high for exactly one cycle and leaves `rst_req_o` low.
- R4: A second timeout with no clear since the first raises `rst_req_o` for exactly RST_LEN consecutive cycles and gives no NMI pulse.
- R5: A timeout restarts the count from zero, so the second timeout comes one full period after the first.
- R6: The clear strobe restarts the count and discards a pending strike, so the next timeout gives an NMI again and not a reset.
- R7: A change of the period select while enabled restarts the count from zero, at the edge that samples the new value.
- R8: While the enable is low, no request is raised and the counter and strike flag stay at zero. Counting resumes from zero on the first enabled edge, and the next timeout gives an NMI.
- R9: Once started, the reset request window runs for its full length, even if the enable drops or the clear strobe arrives during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_en_i | input | 1 | Watchdog enable |
| period_sel_i | input | 2 | Timeout period select |
| clear_i | input | 1 | Software clear strobe |
| nmi_req_o | output | 1 | One-cycle processing-error interrupt request |
| rst_req_o | output | 1 | Stretched system reset request |

## Verification
A counter that is off by one cycle moves the NMI pulse to another cycle. It shows at the ports within one period of the clear or the select change that started the count. A lost or stale strike flag turns an expected NMI into a reset request, or the reverse, at the next timeout. So it shows no later than two periods after a clear. A wrong count in the stretch logic changes the reset window length, and this is visible when the window closes. A bench model that tracks every cycle compares both outputs on each clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WDT_SEL_SHORT = 2'd0,
    WDT_SEL_MID   = 2'd1,
    WDT_SEL_LONG  = 2'd2,
    WDT_SEL_ALIAS = 2'd3
  } wdt_sel_e;

  function automatic int wdt_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int P0_EXP = 16,
  parameter int P1_EXP = 18,
  parameter int P2_EXP = 20,
  parameter int CW     = 20
) (
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] term_o
);
  localparam logic [CW-1:0] TERM0 = CW'((64'd1 << P0_EXP) - 64'd1);
  localparam logic [CW-1:0] TERM1 = CW'((64'd1 << P1_EXP) - 64'd1);
  localparam logic [CW-1:0] TERM2 = CW'((64'd1 << P2_EXP) - 64'd1);

  always_comb begin
    unique case (wdt_sel_e'(sel_i))
      WDT_SEL_SHORT: term_o = TERM0;
      WDT_SEL_MID:   term_o = TERM1;
      default:       term_o = TERM2;
    endcase
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          clear_i,
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] term_i,
  output logic          tmo_o
);
  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  logic          sel_chg;

  assign sel_chg = (sel_i != sel_q);
  assign tmo_o   = en_i && !clear_i && !sel_chg && (cnt == term_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_i;
      if (!en_i || clear_i || sel_chg || tmo_o) cnt <= '0;
      else                                     cnt <= cnt + 1'b1;
    end
  end

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt == '0));
  a_r5_restart_after_timeout: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> (cnt == '0));
  a_r7_select_restart: assert property (@(posedge clk) disable iff (rst)
    (en_i && sel_chg) |=> (cnt == '0));
  a_r2_within_period: assert property (@(posedge clk) disable iff (rst)
    !sel_chg |-> (cnt <= term_i));
endmodule

// File: rtl/wdt_strike.sv
module wdt_strike (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clear_i,
  input  logic tmo_i,
  output logic nmi_o,
  output logic trig_o
);
  logic strike;

  assign trig_o = tmo_i && strike;

  always_ff @(posedge clk) begin
    if (rst) begin
      strike <= 1'b0;
      nmi_o  <= 1'b0;
    end else begin
      nmi_o <= tmo_i && !strike;
      if (!en_i || clear_i) strike <= 1'b0;
      else if (tmo_i)       strike <= !strike;
    end
  end

  a_r3_nmi_single: assert property (@(posedge clk) disable iff (rst)
    nmi_o |=> !nmi_o);
  a_r6_clear_drops_strike: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !strike);
  a_r4_second_no_nmi: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !nmi_o);
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic req_o
);
  generate
    if (LEN <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) req_o <= 1'b0;
        else     req_o <= trig_i;
      end
    end else begin : g_window
      localparam int RW = $clog2(LEN + 1);
      logic [RW-1:0] rem_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          rem_q <= '0;
          req_o <= 1'b0;
        end else begin
          req_o <= trig_i || (rem_q > RW'(1));
          if (trig_i)              rem_q <= RW'(LEN);
          else if (rem_q != '0)    rem_q <= rem_q - 1'b1;
        end
      end

      a_r9_window_held: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |=> req_o);
    end
  endgenerate
endmodule

// File: rtl/two_strike_wdt.sv
module two_strike_wdt
  import wdt_pkg::*;
#(
  parameter int P0_EXP  = 16,
  parameter int P1_EXP  = 18,
  parameter int P2_EXP  = 20,
  parameter int RST_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdt_en_i,
  input  logic [1:0] period_sel_i,
  input  logic       clear_i,
  output logic       nmi_req_o,
  output logic       rst_req_o
);
  localparam int CW = wdt_max3(P0_EXP, P1_EXP, P2_EXP);

  logic [CW-1:0] term;
  logic          tmo;
  logic          trig;

  wdt_period_sel #(
    .P0_EXP(P0_EXP), .P1_EXP(P1_EXP), .P2_EXP(P2_EXP), .CW(CW)
  ) i_sel (
    .sel_i  (period_sel_i),
    .term_o (term)
  );

  wdt_count #(.CW(CW)) i_count (
    .clk     (clk),
    .rst     (rst),
    .en_i    (wdt_en_i),
    .clear_i (clear_i),
    .sel_i   (period_sel_i),
    .term_i  (term),
    .tmo_o   (tmo)
  );

  wdt_strike i_strike (
    .clk     (clk),
    .rst     (rst),
    .en_i    (wdt_en_i),
    .clear_i (clear_i),
    .tmo_i   (tmo),
    .nmi_o   (nmi_req_o),
    .trig_o  (trig)
  );

  wdt_stretch #(.LEN(RST_LEN)) i_stretch (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig),
    .req_o  (rst_req_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!nmi_req_o && !rst_req_o));
endmodule

// File: tb/test_two_strike_wdt.sv
module test_two_strike_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int E0 = 4;
  localparam int E1 = 6;
  localparam int E2 = 8;
  localparam int RLEN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic kick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic nmi, rq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_strike_wdt #(.P0_EXP(E0), .P1_EXP(E1), .P2_EXP(E2), .RST_LEN(RLEN)) i_two_strike_wdt (
    .clk(clk), .rst(rst), .wdt_en_i(en), .period_sel_i(sel), .clear_i(kick),
    .nmi_req_o(nmi), .rst_req_o(rq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt = 0, m_prev = 0, m_rem = 0;
  bit m_strike = 0, m_nmi = 0, m_rq = 0;
  always @(posedge clk) begin
    int lim;
    bit tmo, trg;
    if (rst) begin
      m_cnt = 0; m_prev = 0; m_rem = 0; m_strike = 0; m_nmi = 0; m_rq = 0;
    end else begin
      lim = 1 << ((sel == 0) ? E0 : (sel == 1) ? E1 : E2);
      tmo = 0;
      if (!en) begin
        m_cnt = 0; m_strike = 0;
      end else if (kick || (int'(sel) != m_prev)) begin
        m_cnt = 0;
        if (kick) m_strike = 0;
      end else if (m_cnt == lim - 1) begin
        m_cnt = 0; tmo = 1;
      end else m_cnt++;
      m_prev = int'(sel);
      m_nmi = tmo && !m_strike;
      trg = tmo && m_strike;
      if (tmo) m_strike = !m_strike;
      if (trg) m_rem = RLEN;
      m_rq = (m_rem > 0);
      if (m_rem > 0) m_rem--;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(nmi === m_nmi, "R3 model nmi", int'(nmi), int'(m_nmi));
      chk(rq === m_rq, "R4 model rst_req", int'(rq), int'(m_rq));
    end
  end

  // Counts edges from the current negedge until the chosen output is high.
  task automatic measure(input bit want_rq, output int n, output int other);
    n = 0; other = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk); kick = 1'b0;
      if (want_rq ? nmi : rq) other++;
    end while (!(want_rq ? rq : nmi) && n < 2000);
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1'b1;
  endtask

  task automatic window_len(output int len);
    len = 1;
    forever begin
      @(negedge clk);
      if (rq) len++; else break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    int n, oth, len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!nmi && !rq, "R1 reset outputs", int'({nmi, rq}), 0);
    @(negedge clk); en = 1'b1;

    // R2: each period select, including the alias code 3
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); sel = 2'(s);
      do_kick();
      measure(1'b0, n, oth);
      chk(n == (1 << ((s == 0) ? E0 : (s == 1) ? E1 : E2)) + 1, "R2 period length", n,
          (1 << ((s == 0) ? E0 : (s == 1) ? E1 : E2)) + 1);
      chk(oth == 0, "R3 no reset on first timeout", oth, 0);
    end

    // R3, R4, R5: first strike then second strike
    @(negedge clk); sel = 2'd0;
    do_kick();
    measure(1'b0, n, oth);
    chk(n == (1 << E0) + 1, "R3 first timeout", n, (1 << E0) + 1);
    chk(!rq, "R3 reset low at nmi", int'(rq), 0);
    measure(1'b1, n, oth);
    chk(n == (1 << E0), "R5 second timeout one period later", n, 1 << E0);
    chk(oth == 0, "R4 no nmi on second timeout", oth, 0);
    window_len(len);
    chk(len == RLEN, "R4 reset window length", len, RLEN);

    // R6: clear between timeouts discards the strike
    do_kick();
    measure(1'b0, n, oth);
    do_kick();
    measure(1'b0, n, oth);
    chk(n == (1 << E0) + 1, "R6 nmi again after clear", n, (1 << E0) + 1);
    chk(oth == 0 && !rq, "R6 no reset after clear", oth, 0);

    // R7: select change restarts the count
    @(negedge clk); sel = 2'd1;
    do_kick();
    repeat (40) @(negedge clk);
    kick = 1'b0;
    sel = 2'd0;
    measure(1'b0, n, oth);
    chk(n == (1 << E0) + 1, "R7 restart on select change", n, (1 << E0) + 1);

    // R8: disable parks the block, re-enable restarts from zero
    @(negedge clk); en = 1'b0;
    oth = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (nmi || rq) oth++;
    end
    chk(oth == 0, "R8 quiet while disabled", oth, 0);
    en = 1'b1;
    measure(1'b0, n, oth);
    chk(n == (1 << E0), "R8 count from zero on enable", n, 1 << E0);
    chk(oth == 0 && !rq, "R8 strike cleared while disabled", oth, 0);

    // R9: window survives disable and clear
    measure(1'b1, n, oth);
    chk(rq, "R9 reset started", int'(rq), 1);
    en = 1'b0; kick = 1'b1;
    len = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (rq) len++;
    end
    kick = 1'b0;
    forever begin
      @(negedge clk);
      if (rq) len++; else break;
    end
    chk(len == RLEN, "R9 window held through disable", len, RLEN);
    en = 1'b1;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule